// File: doc/BRIEF.md
# Staged Zero/Invert 16-bit Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for a small 16-bit datapath. It takes two two's-complement operands, `opa` and `opb`, and a six-bit control word. It returns a 16-bit result and two status flags: one says the result is zero, the other says the result is negative. There is no clock, no register, no carry-out and no overflow flag.

Every operation comes from one fixed chain of stages:
1. Each operand may be forced to zero, then may be inverted.
2. The two prepared operands are either added or bitwise ANDed.
3. The output may be inverted.

The control word sets each stage with one bit. A small set of fixed control codes gives the following:
- constants;
- pass-through of either operand;
- bitwise NOT;
- negation;
- increment and decrement;
- add and subtract;
- AND and OR.

A sequencer or instruction decoder drives the control word straight from an instruction field.

Control bit positions, with the code read as a hex number (bit 5 is the MSB):

| Bit | Stage |
|-----|-------|
| 5 | clear `opa` |
| 4 | invert `opa` |
| 3 | clear `opb` |
| 2 | invert `opb` |
| 1 | select add (1) or AND (0) |
| 0 | invert the output |

The stages apply in the order clear, then invert, then combine, then invert the output.

Top module: `chain_alu`

## Requirements
- R1: Code 0x2A gives 0x0000, code 0x3F gives 0x0001 and code 0x3A gives 0xFFFF, whatever the operands.
- R2: Code 0x0C gives `opa`, 0x30 gives `opb`, 0x0D gives the bitwise NOT of `opa` and 0x31 gives the bitwise NOT of `opb`.
- R3: Code 0x0F gives the two's-complement negation of `opa` and 0x33 gives the negation of `opb`.
- R4: Code 0x1F gives `opa`+1, 0x37 gives `opb`+1, 0x0E gives `opa`-1 and 0x32 gives `opb`-1.
- R5: Code 0x02 gives `opa`+`opb`, 0x13 gives `opa`-`opb`, 0x07 gives `opb`-`opa`, 0x00 gives `opa` AND `opb`, and 0x15 gives `opa` OR `opb`.
- R6: `is_zero` is 1 exactly when all 16 result bits are 0.
- R7: `is_neg` equals result bit 15.
- R8: Addition, increment, decrement and subtraction wrap modulo 2^16, with no sign of the carry anywhere.
- R9: A code outside the listed set is not an error. It gives the value of the stage chain for that code. For example:
  - 0x01 gives NOT(`opa` AND `opb`);
  - 0x03 gives NOT(`opa`+`opb`);
  - 0x3E gives 0xFFFE;
  - 0x20 gives 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 16 | First operand, two's complement |
| opb | input | 16 | Second operand, two's complement |
| ctl | input | 6 | Control word: bit 5 clear `opa`, bit 4 invert `opa`, bit 3 clear `opb`, bit 2 invert `opb`, bit 1 add/AND, bit 0 invert output |
| res | output | 16 | Result word |
| is_zero | output | 1 | High when `res` is all zeros |
| is_neg | output | 1 | Copy of `res` bit 15 |

## Verification
The bench sweeps every listed code with these operands:
- random operands;
- 0x0000, 0xFFFF, 0x7FFF and 0x8000, where carries and signs flip.

It probes the following corner cases, each aimed at a specific design fault:
- Wrap at 0xFFFF+1 and 0x8000-1: a design that kept a 17th bit, or saturated, would return a wrong low word or a wrong zero flag.
- Operations run on opposite operands, such as y-x against x-y and `opb`+1 against `opa`+1: swapped operand paths show up as a mismatch.
- The OR code and the unlisted codes: a design that applied the output inversion before the combine step, or decoded only the listed codes, would return a wrong value there.
- Results of 0x8000 and 0x0000: these separate a flag taken from the wrong bit from a correct one.

// File: rtl/chain_alu_pkg.sv
package chain_alu_pkg;

  // Control word, MSB first: the first member is bit 5.
  typedef struct packed {
    logic clr_a;
    logic inv_a;
    logic clr_b;
    logic inv_b;
    logic use_sum;
    logic inv_out;
  } alu_ctl_t;

  localparam int CTL_W = $bits(alu_ctl_t);

  localparam logic [CTL_W-1:0] OP_ZERO  = 6'h2A;
  localparam logic [CTL_W-1:0] OP_ONE   = 6'h3F;
  localparam logic [CTL_W-1:0] OP_MONE  = 6'h3A;
  localparam logic [CTL_W-1:0] OP_PASSA = 6'h0C;
  localparam logic [CTL_W-1:0] OP_NEGA  = 6'h0F;
  localparam logic [CTL_W-1:0] OP_INCA  = 6'h1F;
  localparam logic [CTL_W-1:0] OP_ADD   = 6'h02;
  localparam logic [CTL_W-1:0] OP_SUBAB = 6'h13;

endpackage

// File: rtl/chain_alu_prep.sv
// One operand conditioning stage: optional clear, then optional invert.
module chain_alu_prep #(
  parameter int W = 16
) (
  input  logic [W-1:0] din,
  input  logic         clr,
  input  logic         inv,
  output logic [W-1:0] dout
);
  logic [W-1:0] cleared;

  always_comb begin
    cleared = clr ? '0 : din;
    dout    = inv ? ~cleared : cleared;
  end
endmodule

// File: rtl/chain_alu_core.sv
// Combine stage: wrapping add or bitwise AND of the two prepared operands.
module chain_alu_core #(
  parameter int W = 16
) (
  input  logic [W-1:0] pa,
  input  logic [W-1:0] pb,
  input  logic         use_sum,
  output logic [W-1:0] comb_out
);
  logic [W-1:0] sum_w;
  logic [W-1:0] and_w;

  always_comb begin
    sum_w    = pa + pb;
    and_w    = pa & pb;
    comb_out = use_sum ? sum_w : and_w;
  end
endmodule

// File: rtl/chain_alu_post.sv
// Output stage: optional invert, then status flags from the final word.
module chain_alu_post #(
  parameter int W = 16
) (
  input  logic [W-1:0] comb_in,
  input  logic         inv_out,
  output logic [W-1:0] res,
  output logic         is_zero,
  output logic         is_neg
);
  logic [W-1:0] fin;

  always_comb begin
    fin     = inv_out ? ~comb_in : comb_in;
    res     = fin;
    is_zero = ~|fin;
    is_neg  = fin[W-1];
  end
endmodule

// File: rtl/chain_alu.sv
module chain_alu
  import chain_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [5:0]       ctl,
  output logic [WIDTH-1:0] res,
  output logic             is_zero,
  output logic             is_neg
);
  localparam int NOPS = 2;

  alu_ctl_t         cw;
  logic [WIDTH-1:0] raw  [NOPS];
  logic [WIDTH-1:0] prep [NOPS];
  logic             clr_v [NOPS];
  logic             inv_v [NOPS];
  logic [WIDTH-1:0] comb_w;

  always_comb begin
    cw       = alu_ctl_t'(ctl);
    raw[0]   = opa;
    raw[1]   = opb;
    clr_v[0] = cw.clr_a;
    inv_v[0] = cw.inv_a;
    clr_v[1] = cw.clr_b;
    inv_v[1] = cw.inv_b;
  end

  for (genvar g = 0; g < NOPS; g++) begin : g_prep
    chain_alu_prep #(.W(WIDTH)) u_prep (
      .din  (raw[g]),
      .clr  (clr_v[g]),
      .inv  (inv_v[g]),
      .dout (prep[g])
    );
  end

  chain_alu_core #(.W(WIDTH)) u_core (
    .pa       (prep[0]),
    .pb       (prep[1]),
    .use_sum  (cw.use_sum),
    .comb_out (comb_w)
  );

  chain_alu_post #(.W(WIDTH)) u_post (
    .comb_in (comb_w),
    .inv_out (cw.inv_out),
    .res     (res),
    .is_zero (is_zero),
    .is_neg  (is_neg)
  );
endmodule

// File: rtl/chain_alu_chk.sv
module chain_alu_chk
  import chain_alu_pkg::*;
#(
  parameter int W = 16
) (
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [5:0]   ctl,
  input logic [W-1:0] res,
  input logic         is_zero,
  input logic         is_neg
);
  logic [W-1:0] all_one;
  logic [W-1:0] one_w;

  always_comb begin
    all_one = '1;
    one_w   = W'(1);

    // R1
    a_r1_const_zero: assert (ctl != OP_ZERO || res == '0);
    a_r1_const_one:  assert (ctl != OP_ONE  || res == one_w);
    // R2
    a_r2_pass_a: assert (ctl != OP_PASSA || res == opa);
    // R3
    a_r3_neg_a: assert (ctl != OP_NEGA || res == W'('0 - opa));
    // R4
    a_r4_inc_a: assert (ctl != OP_INCA || res == W'(opa + one_w));
    // R5
    a_r5_sub_ab: assert (ctl != OP_SUBAB || res == W'(opa - opb));
    // R6, R7: a zero word cannot also be negative
    a_r6_flags_exclusive: assert (!(is_zero && is_neg));
    // R8
    a_r8_wrap_add: assert (!(ctl == OP_ADD && opa == all_one && opb == one_w)
                           || (res == '0 && is_zero));
  end
endmodule

bind chain_alu chain_alu_chk #(.W(WIDTH)) u_chk (
  .opa     (opa),
  .opb     (opb),
  .ctl     (ctl),
  .res     (res),
  .is_zero (is_zero),
  .is_neg  (is_neg)
);

// File: tb/tb_chain_alu.sv
module tb_chain_alu;
  localparam int W = 16;

  typedef struct {
    logic [W-1:0] exp_res;
    logic [5:0]   code;
    string        tag;
  } item_t;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] opa;
  logic [W-1:0] opb;
  logic [5:0]   ctl;
  logic [W-1:0] res;
  logic         is_zero;
  logic         is_neg;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  item_t sb_q[$];

  chain_alu #(.WIDTH(W)) dut (
    .opa(opa), .opb(opb), .ctl(ctl),
    .res(res), .is_zero(is_zero), .is_neg(is_neg)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Expected value from the operation each code names.
  function automatic logic [W-1:0] ref_op(input logic [5:0] c,
                                          input logic [W-1:0] x,
                                          input logic [W-1:0] y);
    case (c)
      6'h2A: return 16'h0000;
      6'h3F: return 16'h0001;
      6'h3A: return 16'hFFFF;
      6'h0C: return x;
      6'h30: return y;
      6'h0D: return ~x;
      6'h31: return ~y;
      6'h0F: return 16'h0000 - x;
      6'h33: return 16'h0000 - y;
      6'h1F: return x + 16'h0001;
      6'h37: return y + 16'h0001;
      6'h0E: return x - 16'h0001;
      6'h32: return y - 16'h0001;
      6'h02: return x + y;
      6'h13: return x - y;
      6'h07: return y - x;
      6'h00: return x & y;
      6'h15: return x | y;
      6'h01: return ~(x & y);
      6'h03: return ~(x + y);
      6'h3E: return 16'hFFFE;
      6'h20: return 16'h0000;
      default: return 16'hxxxx;
    endcase
  endfunction

  function automatic string tag_of(input logic [5:0] c);
    case (c)
      6'h2A, 6'h3F, 6'h3A:                return "R1";
      6'h0C, 6'h30, 6'h0D, 6'h31:         return "R2";
      6'h0F, 6'h33:                       return "R3";
      6'h1F, 6'h37, 6'h0E, 6'h32:         return "R4";
      6'h02, 6'h13, 6'h07, 6'h00, 6'h15:  return "R5";
      default:                            return "R9";
    endcase
  endfunction

  // Driver: apply one vector at a rising edge, queue its expectation.
  task automatic drive(input logic [5:0] c, input logic [W-1:0] x,
                       input logic [W-1:0] y, input string tg);
    item_t it;
    @(posedge clk);
    opa = x;
    opb = y;
    ctl = c;
    it.exp_res = ref_op(c, x, y);
    it.code    = c;
    it.tag     = tg;
    sb_q.push_back(it);
  endtask

  // Monitor: compare on the falling edge, after the inputs have settled.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (res !== it.exp_res) begin
        errors++;
        $display("FAIL %s code=%h res actual=%h expected=%h",
                 it.tag, it.code, res, it.exp_res);
      end
      checks++;
      if (is_zero !== (it.exp_res == '0)) begin
        errors++;
        $display("FAIL R6 code=%h is_zero actual=%b expected=%b",
                 it.code, is_zero, (it.exp_res == '0));
      end
      checks++;
      if (is_neg !== it.exp_res[W-1]) begin
        errors++;
        $display("FAIL R7 code=%h is_neg actual=%b expected=%b",
                 it.code, is_neg, it.exp_res[W-1]);
      end
    end
  end

  initial begin
    logic [5:0]   codes [22];
    logic [W-1:0] corners [5];
    codes   = '{6'h2A, 6'h3F, 6'h3A, 6'h0C, 6'h30, 6'h0D, 6'h31, 6'h0F,
                6'h33, 6'h1F, 6'h37, 6'h0E, 6'h32, 6'h02, 6'h13, 6'h07,
                6'h00, 6'h15, 6'h01, 6'h03, 6'h3E, 6'h20};
    corners = '{16'h0000, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h0001};
    rst_n = 1'b0;
    opa = '0;
    opb = '0;
    ctl = 6'h00;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Reset-state vector: zero operands, AND code, result 0 with zero flag.
    drive(6'h00, 16'h0000, 16'h0000, "R5");

    // R8 wrap cases
    drive(6'h02, 16'hFFFF, 16'h0001, "R8");
    drive(6'h1F, 16'hFFFF, 16'h1234, "R8");
    drive(6'h0E, 16'h8000, 16'h0000, "R8");
    drive(6'h13, 16'h0000, 16'h0001, "R8");
    drive(6'h32, 16'h0000, 16'h0000, "R8");
    drive(6'h02, 16'h7FFF, 16'h0001, "R8");

    // Corner sweep: every code against every corner pair
    for (int c = 0; c < 22; c++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          drive(codes[c], corners[i], corners[j], tag_of(codes[c]));

    // Random sweep
    for (int n = 0; n < 40; n++)
      for (int c = 0; c < 22; c++)
        drive(codes[c], W'($urandom), W'($urandom), tag_of(codes[c]));

    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule